// File: doc/BRIEF.md
# Core Idle-Depth Power Sequencer

This block takes a single in-order core from the running state into one of three idle depths and brings it back. Software asks for a depth. The sequencer then steps through the shutdown actions in a fixed order. It asks the L1 caches to flush and waits for their acknowledgement. It stops the core clock, turns the PLL off, saves the architectural state into an external retention array through a request/acknowledge pair, and finally cuts core power together with the bulk I/O plane. A shallow depth stops after the clock is gated. A middle depth also stops the PLL. The deepest depth runs every step.

A wake event undoes the steps in reverse order: power, restore, PLL, clock. The ready output rises a fixed, parameter-set number of cycles after the wake is sampled, so the exit cost of each depth can be modelled in clock cycles. A wake that arrives while entry is still in progress lets the current step finish, then unwinds only the steps already taken. While running, the core has two operating points: a high and a low PLL ratio, chosen by one input.

Top module: `psq_sleep_seq`

## Requirements
- R1: After reset `core_ready`, `core_clk_en`, `pll_en`, `core_pwr_en` and `io_bulk_en` are 1. `flush_req`, `save_req` and `restore_req` are 0. `pstate` is 0 and `pll_ratio` equals RATIO_HI.
- R2: While `pstate` is 0, `pll_ratio` becomes RATIO_LO (when `perf_lo`=1) or RATIO_HI (when `perf_lo`=0) one cycle after `perf_lo` is sampled. While `pstate` is not 0, the ratio holds its value.
- R3: `req_depth` encoding: 0 = no sleep, and the request is dropped. 1 = light: clock off, PLL and power on. 2 = mid: clock and PLL off, power on. 3 = deep: clock, PLL, core power and bulk I/O all off.
- R4: Entry order: `flush_req` is held until `flush_ack`. Then the clock stops, then the PLL stops. Then `save_req` is held until `save_ack`, and then power is removed. The PLL is never off with the clock running, and power is never off with the PLL running.
- R5: From the clock edge that samples `wake` in the asleep state, `core_ready` rises exactly LAT_LIGHT, LAT_MID or LAT_DEEP cycles later, for depth 1, 2 or 3 (each latency at least 6).
- R6: Exit order from deep sleep: power returns first. Then `restore_req` pulses for one cycle while the PLL is still off. Then the PLL returns, then the clock. All of this happens before `core_ready`.
- R7: A wake seen during entry (`pstate` 1) aborts at the end of the current step. The taken steps are unwound (`pstate` 4), the asleep state (2) is never reached, and `core_ready` returns with `pstate` 0.
- R8: Requests arriving while `pstate` is not 0 are dropped without any effect on the outputs. A wake while `pstate` is 0 has no effect.
- R9: `pstate` reports 0 running, 1 entering, 2 asleep, 3 waking, 4 unwinding. `sleep_depth` gives the accepted depth while not running, and 0 while running. `core_ready` is 1 exactly when `pstate` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Idle request strobe |
| req_depth | input | 2 | Requested idle depth (0..3) |
| perf_lo | input | 1 | Select the low-frequency operating point |
| wake | input | 1 | Wake event |
| flush_ack | input | 1 | L1 flush finished |
| save_ack | input | 1 | Retention save finished |
| core_clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL enable |
| pll_ratio | output | RATIO_W | PLL multiplier for the current operating point |
| flush_req | output | 1 | L1 flush request |
| save_req | output | 1 | Retention save request |
| restore_req | output | 1 | Retention restore pulse |
| core_pwr_en | output | 1 | Core power switch enable |
| io_bulk_en | output | 1 | Bulk I/O power plane enable |
| core_ready | output | 1 | Core may run |
| pstate | output | 3 | Sequencer state |
| sleep_depth | output | 2 | Accepted idle depth |

## Verification
A wrong step level inside the sequencer appears at once on the enable outputs. Every enable is registered from the next level, so a skipped or repeated step shows the clock, PLL and power enables in an illegal combination on the very next cycle, or shows the final pattern of the wrong depth once `pstate` reads 2. A wrong latency count does not show while the core sleeps. It appears only when the wake is served, as `core_ready` rising early or late against the programmed cycle count. A lost abort flag shows up as `pstate` 2 being reached after a wake during entry.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [2:0] {
    PS_ACTIVE = 3'd0,
    PS_ENTER  = 3'd1,
    PS_SLEEP  = 3'd2,
    PS_EXIT   = 3'd3,
    PS_UNWIND = 3'd4
  } psq_state_e;

  // number of shutdown steps already taken
  localparam logic [2:0] LV_NONE    = 3'd0;
  localparam logic [2:0] LV_FLUSHED = 3'd1;
  localparam logic [2:0] LV_CLKOFF  = 3'd2;
  localparam logic [2:0] LV_PLLOFF  = 3'd3;
  localparam logic [2:0] LV_SAVED   = 3'd4;
  localparam logic [2:0] LV_PWROFF  = 3'd5;

  function automatic logic [2:0] depth_target(input logic [1:0] d);
    case (d)
      2'd1:    return LV_CLKOFF;
      2'd2:    return LV_PLLOFF;
      2'd3:    return LV_PWROFF;
      default: return LV_NONE;
    endcase
  endfunction
endpackage

// File: rtl/psq_lat_timer.sv
module psq_lat_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/psq_ratio_reg.sv
module psq_ratio_reg #(
  parameter int RATIO_W  = 6,
  parameter int RATIO_HI = 20,
  parameter int RATIO_LO = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic               perf_lo,
  output logic [RATIO_W-1:0] ratio
);
  localparam logic [RATIO_W-1:0] HI_V = RATIO_W'(RATIO_HI);
  localparam logic [RATIO_W-1:0] LO_V = RATIO_W'(RATIO_LO);

  always_ff @(posedge clk) begin
    if (rst)        ratio <= HI_V;
    else if (!hold) ratio <= perf_lo ? LO_V : HI_V;
  end
endmodule

// File: rtl/psq_step_fsm.sv
module psq_step_fsm
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_depth,
  input  logic       wake,
  input  logic       flush_ack,
  input  logic       save_ack,
  input  logic       tmr_zero,
  output logic       tmr_load,
  output logic [2:0] st_o,
  output logic [1:0] tgt,
  output logic       core_clk_en,
  output logic       pll_en,
  output logic       core_pwr_en,
  output logic       io_bulk_en,
  output logic       flush_req,
  output logic       save_req,
  output logic       restore_req,
  output logic       core_ready
);
  psq_state_e st, st_n;
  logic [2:0] lv, lv_n, lv_inc;
  logic [1:0] tgt_n;
  logic       pend, pend_n, step_done;

  assign lv_inc   = lv + 3'd1;
  assign tmr_load = (st == PS_SLEEP) && wake;
  assign st_o     = st;

  always_comb begin
    st_n      = st;
    lv_n      = lv;
    tgt_n     = tgt;
    pend_n    = pend;
    step_done = 1'b0;
    case (st)
      PS_ACTIVE: begin
        pend_n = 1'b0;
        if (req_valid && req_depth != 2'd0) begin
          st_n  = PS_ENTER;
          tgt_n = req_depth;
        end
      end
      PS_ENTER: begin
        pend_n = pend | wake;
        case (lv)
          LV_NONE:   step_done = flush_ack;
          LV_PLLOFF: step_done = save_ack;
          default:   step_done = 1'b1;
        endcase
        if (step_done) begin
          lv_n = lv_inc;
          if (pend || wake)                  st_n = PS_UNWIND;
          else if (lv_inc == depth_target(tgt)) st_n = PS_SLEEP;
        end
      end
      PS_SLEEP: begin
        if (wake) st_n = PS_EXIT;
      end
      PS_EXIT: begin
        if (lv != LV_NONE) lv_n = lv - 3'd1;
        if (tmr_zero) begin
          st_n  = PS_ACTIVE;
          tgt_n = 2'd0;
        end
      end
      PS_UNWIND: begin
        if (lv != LV_NONE) lv_n = lv - 3'd1;
        else begin
          st_n  = PS_ACTIVE;
          tgt_n = 2'd0;
        end
      end
      default: begin
        st_n  = PS_ACTIVE;
        lv_n  = LV_NONE;
        tgt_n = 2'd0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= PS_ACTIVE;
      lv          <= LV_NONE;
      tgt         <= 2'd0;
      pend        <= 1'b0;
      core_clk_en <= 1'b1;
      pll_en      <= 1'b1;
      core_pwr_en <= 1'b1;
      io_bulk_en  <= 1'b1;
      flush_req   <= 1'b0;
      save_req    <= 1'b0;
      restore_req <= 1'b0;
      core_ready  <= 1'b1;
    end else begin
      st          <= st_n;
      lv          <= lv_n;
      tgt         <= tgt_n;
      pend        <= pend_n;
      core_clk_en <= lv_n < LV_CLKOFF;
      pll_en      <= lv_n < LV_PLLOFF;
      core_pwr_en <= lv_n < LV_PWROFF;
      io_bulk_en  <= lv_n < LV_PWROFF;
      flush_req   <= (st_n == PS_ENTER) && (lv_n == LV_NONE);
      save_req    <= (st_n == PS_ENTER) && (lv_n == LV_PLLOFF);
      restore_req <= (st_n == PS_EXIT || st_n == PS_UNWIND) && (lv_n == LV_SAVED);
      core_ready  <= st_n == PS_ACTIVE;
    end
  end
endmodule

// File: rtl/psq_sleep_seq.sv
module psq_sleep_seq #(
  parameter int LAT_LIGHT = 8,
  parameter int LAT_MID   = 40,
  parameter int LAT_DEEP  = 120,
  parameter int RATIO_W   = 6,
  parameter int RATIO_HI  = 20,
  parameter int RATIO_LO  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_depth,
  input  logic               perf_lo,
  input  logic               wake,
  input  logic               flush_ack,
  input  logic               save_ack,
  output logic               core_clk_en,
  output logic               pll_en,
  output logic [RATIO_W-1:0] pll_ratio,
  output logic               flush_req,
  output logic               save_req,
  output logic               restore_req,
  output logic               core_pwr_en,
  output logic               io_bulk_en,
  output logic               core_ready,
  output logic [2:0]         pstate,
  output logic [1:0]         sleep_depth
);
  localparam int LAT_MAX = (LAT_DEEP > LAT_MID)
                         ? ((LAT_DEEP > LAT_LIGHT) ? LAT_DEEP : LAT_LIGHT)
                         : ((LAT_MID > LAT_LIGHT) ? LAT_MID : LAT_LIGHT);
  localparam int CNT_W = $clog2(LAT_MAX + 1);

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] lat_sel;
  logic [2:0]       st;
  logic [1:0]       tgt;

  always_comb begin
    case (tgt)
      2'd1:    lat_sel = CNT_W'(LAT_LIGHT - 1);
      2'd2:    lat_sel = CNT_W'(LAT_MID - 1);
      default: lat_sel = CNT_W'(LAT_DEEP - 1);
    endcase
  end

  psq_step_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_depth(req_depth),
    .wake(wake), .flush_ack(flush_ack), .save_ack(save_ack),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .st_o(st), .tgt(tgt),
    .core_clk_en(core_clk_en), .pll_en(pll_en), .core_pwr_en(core_pwr_en),
    .io_bulk_en(io_bulk_en), .flush_req(flush_req), .save_req(save_req),
    .restore_req(restore_req), .core_ready(core_ready)
  );

  psq_lat_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(lat_sel), .zero(tmr_zero)
  );

  psq_ratio_reg #(.RATIO_W(RATIO_W), .RATIO_HI(RATIO_HI), .RATIO_LO(RATIO_LO)) u_ratio (
    .clk(clk), .rst(rst), .hold(st != 3'd0), .perf_lo(perf_lo), .ratio(pll_ratio)
  );

  assign pstate      = st;
  assign sleep_depth = tgt;
endmodule

// File: rtl/psq_sleep_seq_chk.sv
module psq_sleep_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wake,
  input logic       core_clk_en,
  input logic       pll_en,
  input logic       core_pwr_en,
  input logic       flush_req,
  input logic       save_req,
  input logic       restore_req,
  input logic       core_ready,
  input logic [2:0] pstate
);
  // R4
  flush_clk_on_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> core_clk_en);
  // R4
  pll_after_clk_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_en |-> !core_clk_en);
  // R4
  pwr_after_pll_chk: assert property (@(posedge clk) disable iff (rst)
    !core_pwr_en |-> !pll_en);
  // R4
  save_window_chk: assert property (@(posedge clk) disable iff (rst)
    save_req |-> (!pll_en && core_pwr_en));
  // R6
  restore_window_chk: assert property (@(posedge clk) disable iff (rst)
    restore_req |-> (core_pwr_en && !pll_en));
  // R6
  restore_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    restore_req |=> !restore_req);
  // R9
  ready_running_chk: assert property (@(posedge clk) disable iff (rst)
    core_ready |-> (pstate == 3'd0 && core_clk_en && pll_en && core_pwr_en));
  // R9
  pstate_range_chk: assert property (@(posedge clk) disable iff (rst)
    pstate <= 3'd4);
  // R8
  asleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pstate == 3'd2 && !wake) |=> (pstate == 3'd2 && $stable(core_clk_en)
                                   && $stable(pll_en) && $stable(core_pwr_en)));
  // R7
  unwind_no_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (pstate == 3'd4) |=> (pstate == 3'd4 || pstate == 3'd0));
endmodule

bind psq_sleep_seq psq_sleep_seq_chk u_chk (
  .clk(clk), .rst(rst), .wake(wake), .core_clk_en(core_clk_en), .pll_en(pll_en),
  .core_pwr_en(core_pwr_en), .flush_req(flush_req), .save_req(save_req),
  .restore_req(restore_req), .core_ready(core_ready), .pstate(pstate)
);

// File: tb/psq_sleep_seq_bench.sv
`timescale 1ns/1ps
module psq_sleep_seq_bench;
  localparam int LAT_L = 8, LAT_M = 40, LAT_D = 120;
  localparam int RW = 6, R_HI = 20, R_LO = 6;

  logic clk = 0, rst = 1;
  logic req_valid = 0, perf_lo = 0, wake = 0, flush_ack = 0, save_ack = 0;
  logic [1:0] req_depth = 0;
  logic core_clk_en, pll_en, flush_req, save_req, restore_req;
  logic core_pwr_en, io_bulk_en, core_ready;
  logic [RW-1:0] pll_ratio;
  logic [2:0] pstate;
  logic [1:0] sleep_depth;

  psq_sleep_seq #(.LAT_LIGHT(LAT_L), .LAT_MID(LAT_M), .LAT_DEEP(LAT_D),
    .RATIO_W(RW), .RATIO_HI(R_HI), .RATIO_LO(R_LO)) u_psq_sleep_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_depth(req_depth),
    .perf_lo(perf_lo), .wake(wake), .flush_ack(flush_ack), .save_ack(save_ack),
    .core_clk_en(core_clk_en), .pll_en(pll_en), .pll_ratio(pll_ratio),
    .flush_req(flush_req), .save_req(save_req), .restore_req(restore_req),
    .core_pwr_en(core_pwr_en), .io_bulk_en(io_bulk_en), .core_ready(core_ready),
    .pstate(pstate), .sleep_depth(sleep_depth));

  always #2.5 clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  bit  ack_f_en = 1, ack_s_en = 1;
  bit  saw_sleep, saw_pll_off, saw_pwr_off, saw_restore;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input int d);
    return (d == 1) ? LAT_L : (d == 2) ? LAT_M : LAT_D;
  endfunction
  function automatic bit exp_pll(input int d); return d < 2; endfunction
  function automatic bit exp_pwr(input int d); return d < 3; endfunction

  // acknowledge responders
  initial forever begin
    @(negedge clk);
    flush_ack = ack_f_en && flush_req && ($urandom_range(0, 2) == 0);
    save_ack  = ack_s_en && save_req  && ($urandom_range(0, 2) == 0);
  end

  // sticky observers
  initial forever begin
    @(negedge clk);
    if (pstate == 3'd2) saw_sleep = 1;
    if (!pll_en) saw_pll_off = 1;
    if (!core_pwr_en) saw_pwr_off = 1;
    if (restore_req) saw_restore = 1;
  end

  task automatic clear_flags();
    saw_sleep = 0; saw_pll_off = 0; saw_pwr_off = 0; saw_restore = 0;
  endtask

  task automatic send_req(input int d);
    @(negedge clk);
    req_valid = 1; req_depth = 2'(d);
    @(negedge clk);
    req_valid = 0; req_depth = 0;
  endtask

  task automatic wait_for(input logic [2:0] s, output bit ok);
    int n = 0;
    while (pstate != s && n < 3000) begin @(negedge clk); n++; end
    ok = (pstate == s);
  endtask

  task automatic check_asleep(input int d);
    bit ok;
    wait_for(3'd2, ok);
    chk(ok, "R3 asleep reached", pstate, 2);
    chk(core_clk_en == 1'b0, "R3 clock off", core_clk_en, 0);
    chk(pll_en == exp_pll(d), "R3 pll pattern", pll_en, exp_pll(d));
    chk(core_pwr_en == exp_pwr(d) && io_bulk_en == exp_pwr(d), "R3 power pattern",
        core_pwr_en, exp_pwr(d));
    chk(sleep_depth == 2'(d) && !core_ready, "R9 depth report", sleep_depth, d);
  endtask

  task automatic wake_and_time(input int d);
    int k, pr, pl, ck, rs;
    @(negedge clk); wake = 1;
    @(negedge clk); wake = 0;
    k = 0; pr = -1; pl = -1; ck = -1; rs = 0;
    while (!core_ready && k < 1000) begin
      @(negedge clk); k++;
      if (core_pwr_en && pr < 0) pr = k;
      if (pll_en && pl < 0) pl = k;
      if (core_clk_en && ck < 0) ck = k;
      if (restore_req) rs++;
    end
    chk(k == exp_lat(d), "R5 exit latency", k, exp_lat(d));
    chk(pstate == 3'd0 && sleep_depth == 0, "R9 running after exit", pstate, 0);
    if (d == 3) begin
      chk(pr < pl && rs == 1, "R6 power then restore then pll", pl - pr, rs);
      chk(pl < ck && ck <= k, "R6 pll then clock before ready", ck, pl + 1);
    end else if (d == 2) begin
      chk(pl < ck && ck <= k, "R6 pll then clock", ck, pl + 1);
    end
  endtask

  task automatic abort_run(input int d, input bit at_save);
    bit ok;
    clear_flags();
    if (at_save) ack_s_en = 0; else ack_f_en = 0;
    send_req(d);
    if (at_save) begin
      int n = 0;
      while (!save_req && n < 200) begin @(negedge clk); n++; end
    end else repeat ($urandom_range(0, 3)) @(negedge clk);
    wake = 1; @(negedge clk); wake = 0;
    ack_f_en = 1; ack_s_en = 1;
    wait_for(3'd0, ok);
    chk(ok && core_ready, "R7 ready after abort", core_ready, 1);
    chk(!saw_sleep, "R7 asleep never reached", saw_sleep, 0);
    if (at_save) begin
      chk(!saw_pwr_off && saw_pll_off, "R7 unwind before power off", saw_pwr_off, 0);
      chk(saw_restore, "R7 restore on unwind", saw_restore, 1);
    end else
      chk(!saw_pll_off, "R7 pll kept on", saw_pll_off, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    bit ok;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(core_ready && core_clk_en && pll_en && core_pwr_en && io_bulk_en,
        "R1 enables after reset", {core_ready, core_clk_en, pll_en, core_pwr_en}, 15);
    chk(!flush_req && !save_req && !restore_req && pstate == 0, "R1 idle outputs", pstate, 0);
    chk(pll_ratio == R_HI, "R1 ratio", pll_ratio, R_HI);

    // R2 operating point
    perf_lo = 1; @(negedge clk);
    chk(pll_ratio == R_LO, "R2 low ratio", pll_ratio, R_LO);
    perf_lo = 0; @(negedge clk);
    chk(pll_ratio == R_HI, "R2 high ratio", pll_ratio, R_HI);

    // R8 wake while running, R3 depth 0 dropped
    wake = 1; @(negedge clk); wake = 0; @(negedge clk);
    chk(core_ready && pstate == 0, "R8 wake while running", pstate, 0);
    send_req(0); @(negedge clk);
    chk(pstate == 0 && core_clk_en, "R3 depth 0 dropped", pstate, 0);

    // each depth, directed
    for (int d = 1; d <= 3; d++) begin
      send_req(d);
      check_asleep(d);
      wake_and_time(d);
    end

    // R2 ratio held while asleep
    perf_lo = 1; @(negedge clk);
    send_req(1);
    check_asleep(1);
    perf_lo = 0; repeat (2) @(negedge clk);
    chk(pll_ratio == R_LO, "R2 ratio held asleep", pll_ratio, R_LO);
    wake_and_time(1);
    @(negedge clk);
    chk(pll_ratio == R_HI, "R2 ratio after wake", pll_ratio, R_HI);

    // R8 requests ignored while asleep
    send_req(2);
    check_asleep(2);
    send_req(1); send_req(3); repeat (2) @(negedge clk);
    chk(pstate == 2 && sleep_depth == 2, "R8 request ignored asleep", sleep_depth, 2);
    chk(pll_en == 0 && core_pwr_en == 1, "R8 outputs unchanged", core_pwr_en, 1);
    wake_and_time(2);

    // R7 directed aborts
    abort_run(3, 0);
    abort_run(3, 1);

    // mixed random runs
    for (int it = 0; it < 30; it++) begin
      int d = $urandom_range(1, 3);
      if ($urandom_range(0, 3) == 0) abort_run(d, (d == 3) && $urandom_range(0, 1) == 1);
      else begin
        send_req(d);
        check_asleep(d);
        repeat ($urandom_range(0, 5)) @(negedge clk);
        wake_and_time(d);
      end
      wait_for(3'd0, ok);
    end
    finish_run();
  end
endmodule